// File: doc/BRIEF.md
# Page Write and Completion Poller

This block is a host-side controller for a byte-wide parallel nonvolatile memory that programs a whole page internally after its bytes are loaded. The controller takes a start address, a byte count from 1 to 64 and a stream of bytes on a valid/ready input. It can first issue a three-write unlock prefix. It then writes each byte with its own chip-enable and write-enable pulse. Every byte lands on the same page: the page is fixed by the upper address bits, and the offset wraps inside the 64-byte page.

After the last byte, the controller reads back the address of the last byte written until the memory reports that programming has finished. There are two ways to judge completion. In data mode, bit 7 must read back true. In toggle mode, bit 6 must stop changing between reads. The controller then pulses `done`. If the memory stays busy too long, it pulses `timeout` instead.

If the byte stream stalls after loading has begun, the memory would start programming by itself. The controller follows the memory: it stops loading, polls the last byte it wrote, and flags the shortened page with `short_load` when `done` is raised.

The control state machine has these states:

- IDLE: waits for `start`. It goes to UNLOCK when `unlock_en` is high, and to LOAD otherwise.
- UNLOCK: issues the three prefix writes. It goes to LOAD when the third write ends.
- LOAD: waits for a byte. It goes to WRITE when it accepts one. It goes to POLL when the load deadline expires.
- WRITE: performs one byte write. When the write ends, it goes back to LOAD, or to POLL after the final byte.
- POLL: repeats read cycles. It goes to DONE on completion. It goes to TIMEOUT when a read ends incomplete after the poll limit.
- DONE and TIMEOUT: each lasts one cycle, then the machine returns to IDLE.

Top module: `page_write_poller`

## Requirements
- R1: A `start` pulse in IDLE captures `start_addr`, `byte_cnt_m1` and `toggle_mode`. A `start` while `busy` is high is ignored. `busy` is high from the cycle after the accepted start through the cycle of `done` or `timeout`.
- R2: When `unlock_en` is high at start, three writes go out before the first data byte: UNLK_ADDR0/UNLK_DATA0, then UNLK_ADDR1/UNLK_DATA1, then UNLK_ADDR2/UNLK_DATA2. When `unlock_en` is low, no prefix is sent.
- R3: Exactly `byte_cnt_m1`+1 data bytes are written, in order of acceptance. Byte k goes to address {start_addr[14:6], (start_addr[5:0]+k) mod 64}.
- R4: In a write cycle, `mem_ce_n` and `mem_we_n` are low for exactly PULSE_CLKS clocks and `mem_oe_n` stays high. Between any two bus cycles, all three strobes stay high for at least GAP_CLKS clocks.
- R5: In a poll read, `mem_ce_n` and `mem_oe_n` are low for exactly PULSE_CLKS clocks, `mem_we_n` is high, and `mem_addr` is the address of the last data byte written.
- R6: With `toggle_mode`=0, polling completes on the first read whose bit 7 equals bit 7 of the last byte written.
- R7: With `toggle_mode`=1, polling completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R8: After at least one data byte has been written, if no further byte is accepted within LOAD_WIN_CLKS clocks of entering LOAD, the controller stops loading. It then polls the last written byte, and `short_load` is 1 in the `done` cycle. In every other case `short_load` is 0.
- R9: If a poll read ends incomplete after POLL_LIMIT or more clocks in POLL, `timeout` pulses and no `done` follows.
- R10: `done` and `timeout` are single-cycle pulses and are never high together. After reset, all strobes are high and `busy`, `done`, `timeout` and `in_ready` are low.
- R11: `in_ready` is high only while the controller waits for a data byte and no bus cycle is active. Each accepted byte produces exactly one write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page operation |
| start_addr | input | 15 | First byte address; bits 14:6 select the page |
| byte_cnt_m1 | input | 6 | Number of bytes minus one |
| unlock_en | input | 1 | Send the three-write unlock prefix |
| toggle_mode | input | 1 | 1: bit-6 toggle completion, 0: bit-7 data completion |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| short_load | output | 1 | With done: page was cut short by the load deadline |
| timeout | output | 1 | Polling gave up |

## Verification
The hardest situations to reach are the ones where the memory never finishes, or where the host stops supplying bytes partway through a page. Neither arises from a well-behaved stream and a well-behaved memory. The bench's memory model can therefore be told to stay busy forever, either holding bit 7 inverted or toggling bit 6 indefinitely, so that both completion modes run into the poll limit. A directed test also withholds the stream after two of four bytes. It then checks that the controller polls the second byte's address and reports a shortened page.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK,
        ST_LOAD,
        ST_WRITE,
        ST_POLL,
        ST_DONE,
        ST_TIMEOUT
    } pwp_state_e;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_ACT,
        BC_REC
    } bc_state_e;
endpackage

// File: rtl/pwp_bus_cycle.sv
module pwp_bus_cycle
    import pwp_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CLKS = 4,
    parameter int GAP_CLKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              idle,
    output logic              fin,
    output logic [DATA_W-1:0] rd_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n
);
    localparam int MAXC = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] P_LAST = CW'(PULSE_CLKS - 1);
    localparam logic [CW-1:0] G_LAST = CW'(GAP_CLKS - 1);

    bc_state_e         st_q;
    logic [CW-1:0]     cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BC_IDLE;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rd_q   <= '0;
        end else begin
            unique case (st_q)
                BC_IDLE: begin
                    if (go) begin
                        st_q   <= BC_ACT;
                        cnt_q  <= P_LAST;
                        wr_q   <= is_wr;
                        addr_q <= addr_in;
                        data_q <= data_in;
                    end
                end
                BC_ACT: begin
                    if (cnt_q == '0) begin
                        st_q  <= BC_REC;
                        cnt_q <= G_LAST;
                        if (!wr_q) rd_q <= rdata_in;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BC_REC: begin
                    if (cnt_q == '0) st_q <= BC_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= BC_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (st_q == BC_IDLE);
        fin       = (st_q == BC_REC) && (cnt_q == '0);
        ce_n      = (st_q != BC_ACT);
        we_n      = !((st_q == BC_ACT) && wr_q);
        oe_n      = !((st_q == BC_ACT) && !wr_q);
        bus_addr  = addr_q;
        bus_wdata = data_q;
    end
endmodule

// File: rtl/pwp_limit_cnt.sv
module pwp_limit_cnt #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (en && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == LIM);
endmodule

// File: rtl/pwp_poll_judge.sv
module pwp_poll_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic toggle_mode,
    input  logic ref_bit7,
    input  logic rd_bit7,
    input  logic rd_bit6,
    output logic complete
);
    logic have_prev_q;
    logic prev6_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_prev_q <= 1'b0;
            prev6_q     <= 1'b0;
        end else if (sample) begin
            have_prev_q <= 1'b1;
            prev6_q     <= rd_bit6;
        end
    end

    assign complete = toggle_mode ? (have_prev_q && (rd_bit6 == prev6_q))
                                  : (rd_bit7 == ref_bit7);
endmodule

// File: rtl/page_write_poller.sv
module page_write_poller
    import pwp_pkg::*;
#(
    parameter int          ADDR_W        = 15,
    parameter int          DATA_W        = 8,
    parameter int          PAGE_BYTES    = 64,
    parameter int          PULSE_CLKS    = 4,
    parameter int          GAP_CLKS      = 2,
    parameter int          LOAD_WIN_CLKS = 10000,
    parameter int          POLL_LIMIT    = 1200000,
    parameter logic [14:0] UNLK_ADDR0    = 15'h5555,
    parameter logic [14:0] UNLK_ADDR1    = 15'h2AAA,
    parameter logic [14:0] UNLK_ADDR2    = 15'h5555,
    parameter logic [7:0]  UNLK_DATA0    = 8'hAA,
    parameter logic [7:0]  UNLK_DATA1    = 8'h55,
    parameter logic [7:0]  UNLK_DATA2    = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_cnt_m1,
    input  logic              unlock_en,
    input  logic              toggle_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              busy,
    output logic              done,
    output logic              short_load,
    output logic              timeout
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    pwp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  cnt_m1_q;
    logic [OFF_W-1:0]  idx_q;
    logic [1:0]        ucnt_q;
    logic              toggle_q;
    logic              short_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [DATA_W-1:0] last_data_q;

    logic              bc_go, bc_wr, bc_idle, bc_fin;
    logic [ADDR_W-1:0] bc_addr;
    logic [DATA_W-1:0] bc_data, bc_rd;
    logic              win_hit, poll_hit, poll_ok;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] unlk_addr;
    logic [DATA_W-1:0] unlk_data;

    logic              data_wr_phase;
    logic [ADDR_W-OFF_W-1:0] page_hi;
    logic              unused_rd_bits;

    assign page_addr     = {base_q[ADDR_W-1:OFF_W], base_q[OFF_W-1:0] + idx_q};
    assign data_wr_phase = (state_q == ST_WRITE);
    assign page_hi       = base_q[ADDR_W-1:OFF_W];
    assign unused_rd_bits = ^bc_rd[DATA_W-3:0];

    always_comb begin
        unique case (ucnt_q)
            2'd0:    begin unlk_addr = UNLK_ADDR0; unlk_data = UNLK_DATA0; end
            2'd1:    begin unlk_addr = UNLK_ADDR1; unlk_data = UNLK_DATA1; end
            default: begin unlk_addr = UNLK_ADDR2; unlk_data = UNLK_DATA2; end
        endcase
    end

    pwp_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PULSE_CLKS(PULSE_CLKS), .GAP_CLKS(GAP_CLKS)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .go(bc_go), .is_wr(bc_wr),
        .addr_in(bc_addr), .data_in(bc_data), .rdata_in(mem_rdata),
        .idle(bc_idle), .fin(bc_fin), .rd_q(bc_rd),
        .bus_addr(mem_addr), .bus_wdata(mem_wdata),
        .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n)
    );

    pwp_limit_cnt #(.LIMIT(LOAD_WIN_CLKS)) u_win (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q != ST_LOAD),
        .en((state_q == ST_LOAD) && (idx_q != '0)),
        .hit(win_hit)
    );

    pwp_limit_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q != ST_POLL),
        .en(state_q == ST_POLL),
        .hit(poll_hit)
    );

    pwp_poll_judge u_judge (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q != ST_POLL),
        .sample((state_q == ST_POLL) && bc_fin),
        .toggle_mode(toggle_q),
        .ref_bit7(last_data_q[DATA_W-1]),
        .rd_bit7(bc_rd[DATA_W-1]),
        .rd_bit6(bc_rd[DATA_W-2]),
        .complete(poll_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = unlock_en ? ST_UNLOCK : ST_LOAD;
            ST_UNLOCK:  if (bc_fin && ucnt_q == 2'd2) state_d = ST_LOAD;
            ST_LOAD: begin
                if (win_hit)    state_d = ST_POLL;
                else if (bc_go) state_d = ST_WRITE;
            end
            ST_WRITE:   if (bc_fin) state_d = (idx_q == cnt_m1_q) ? ST_POLL : ST_LOAD;
            ST_POLL: begin
                if (bc_fin) begin
                    if (poll_ok)       state_d = ST_DONE;
                    else if (poll_hit) state_d = ST_TIMEOUT;
                end
            end
            ST_DONE:    state_d = ST_IDLE;
            ST_TIMEOUT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and bus requests
    always_comb begin
        in_ready   = (state_q == ST_LOAD) && bc_idle && !win_hit;
        bc_go      = 1'b0;
        bc_wr      = 1'b1;
        bc_addr    = page_addr;
        bc_data    = in_data;
        unique case (state_q)
            ST_UNLOCK: begin
                bc_go   = bc_idle;
                bc_addr = unlk_addr;
                bc_data = unlk_data;
            end
            ST_LOAD:   bc_go = in_valid && in_ready;
            ST_POLL: begin
                bc_go   = bc_idle;
                bc_wr   = 1'b0;
                bc_addr = last_addr_q;
            end
            default: ;
        endcase
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        timeout    = (state_q == ST_TIMEOUT);
        short_load = (state_q == ST_DONE) && short_q;
    end

    // captured operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            cnt_m1_q    <= '0;
            idx_q       <= '0;
            ucnt_q      <= '0;
            toggle_q    <= 1'b0;
            short_q     <= 1'b0;
            last_addr_q <= '0;
            last_data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q   <= start_addr;
                        cnt_m1_q <= byte_cnt_m1;
                        toggle_q <= toggle_mode;
                        idx_q    <= '0;
                        ucnt_q   <= '0;
                        short_q  <= 1'b0;
                    end
                end
                ST_UNLOCK: if (bc_fin) ucnt_q <= ucnt_q + 2'd1;
                ST_LOAD: begin
                    if (win_hit) begin
                        short_q <= 1'b1;
                    end else if (bc_go) begin
                        last_addr_q <= page_addr;
                        last_data_q <= in_data;
                    end
                end
                ST_WRITE: if (bc_fin && idx_q != cnt_m1_q) idx_q <= idx_q + OFF_W'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
    parameter int ADDR_W     = 15,
    parameter int OFF_W      = 6,
    parameter int PULSE_CLKS = 4,
    parameter int GAP_CLKS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              done,
    input logic              timeout,
    input logic              in_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              data_wr_phase,
    input logic [ADDR_W-OFF_W-1:0] page_hi
);
    localparam int RW = $clog2(PULSE_CLKS + 2);
    localparam int GW = $clog2(GAP_CLKS + 2);
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};
    localparam logic [GW-1:0] GMAX = {GW{1'b1}};

    logic [RW-1:0] we_run, oe_run;
    logic [GW-1:0] hi_run;
    logic          unused_lo;

    assign unused_lo = ^mem_addr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
            hi_run <= GW'(GAP_CLKS);
        end else begin
            we_run <= we_n ? '0 : ((we_run == RMAX) ? we_run : we_run + 1'b1);
            oe_run <= oe_n ? '0 : ((oe_run == RMAX) ? oe_run : oe_run + 1'b1);
            hi_run <= !ce_n ? '0 : ((hi_run == GMAX) ? hi_run : hi_run + 1'b1);
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n)); // R4
    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !oe_n) |-> !ce_n); // R5
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (we_n && we_run != '0) |-> we_run == RW'(PULSE_CLKS)); // R4
    AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (oe_n && oe_run != '0) |-> oe_run == RW'(PULSE_CLKS)); // R5
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) (!ce_n && hi_run != '0) |-> hi_run >= GW'(GAP_CLKS)); // R4
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (data_wr_phase && !we_n) |-> mem_addr[ADDR_W-1:OFF_W] == page_hi); // R3
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && timeout)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout); // R9
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (ce_n && we_n && oe_n)); // R11
endmodule

bind page_write_poller pwp_checker #(
    .ADDR_W(ADDR_W), .OFF_W($clog2(PAGE_BYTES)),
    .PULSE_CLKS(PULSE_CLKS), .GAP_CLKS(GAP_CLKS)
) u_pwp_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .done(done), .timeout(timeout), .in_ready(in_ready), .mem_addr(mem_addr),
    .data_wr_phase(data_wr_phase), .page_hi(page_hi)
);

// File: tb/page_write_poller_tb_top.sv
module page_write_poller_tb_top;
    localparam int PULSE = 3;
    localparam int GAP   = 2;
    localparam int WIN   = 40;
    localparam int PLIM  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] start_addr = '0;
    logic [5:0]  byte_cnt_m1 = '0;
    logic        unlock_en = 1'b0;
    logic        toggle_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic        busy, done, short_load, timeout;

    always #5 clk = ~clk;

    page_write_poller #(
        .PULSE_CLKS(PULSE), .GAP_CLKS(GAP), .LOAD_WIN_CLKS(WIN), .POLL_LIMIT(PLIM),
        .UNLK_ADDR0(15'h5555), .UNLK_ADDR1(15'h2AAA), .UNLK_ADDR2(15'h5555),
        .UNLK_DATA0(8'hAA), .UNLK_DATA1(8'h55), .UNLK_DATA2(8'hA0)
    ) dut_i (.*);

    // ---------------- memory model (updates at negedge) ----------------
    int          m_prog;
    logic        m_stuck;
    int          prog_cnt;
    logic        mbusy;
    logic        tog;
    logic [7:0]  last_d;
    logic [14:0] wlog_a [0:127];
    logic [7:0]  wlog_d [0:127];
    int          nw;
    logic [14:0] rlog_a [0:1023];
    int          nr;
    int          width_bad, gap_bad;
    int          we_run, oe_run, hi_run;
    logic        wr_prev, rd_prev;

    assign mbusy     = m_stuck || (prog_cnt != 0);
    assign mem_rdata = mbusy ? {~last_d[7], tog, last_d[5:0]} : last_d;

    task automatic clear_logs();
        nw = 0; nr = 0; width_bad = 0; gap_bad = 0;
    endtask

    initial begin
        prog_cnt = 0; tog = 1'b0; last_d = '0; m_prog = 0; m_stuck = 1'b0;
        we_run = 0; oe_run = 0; hi_run = 100; wr_prev = 1'b0; rd_prev = 1'b0;
        clear_logs();
    end

    always @(negedge clk) begin
        logic wr_now, rd_now;
        wr_now = !mem_ce_n && !mem_we_n;
        rd_now = !mem_ce_n && !mem_oe_n;
        if ((wr_now || rd_now) && mem_ce_n == 1'b0 && hi_run < GAP && (wr_now != wr_prev || rd_now != rd_prev))
            gap_bad++;
        if (wr_now && !wr_prev) begin
            if (nw < 128) begin wlog_a[nw] = mem_addr; wlog_d[nw] = mem_wdata; end
            nw++;
            last_d   = mem_wdata;
            prog_cnt = m_prog;
        end else if (prog_cnt != 0) begin
            prog_cnt--;
        end
        if (rd_now && !rd_prev) begin
            if (nr < 1024) rlog_a[nr] = mem_addr;
            nr++;
        end
        if (!rd_now && rd_prev && mbusy) tog = ~tog;
        if (wr_now) we_run++;
        else if (we_run != 0) begin
            if (we_run != PULSE || !mem_oe_n) width_bad++;
            we_run = 0;
        end
        if (rd_now) oe_run++;
        else if (oe_run != 0) begin
            if (oe_run != PULSE) width_bad++;
            oe_run = 0;
        end
        if (wr_now && !mem_oe_n) width_bad++;
        hi_run  = (mem_ce_n) ? hi_run + 1 : 0;
        wr_prev = wr_now;
        rd_prev = rd_now;
    end

    // ---------------- checking helpers ----------------
    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bytef(input int v, input int i);
        return 8'(i * 29 + v * 7 + 90);
    endfunction

    function automatic logic [14:0] paddr(input logic [14:0] b, input int i);
        logic [5:0] lo;
        lo = 6'(int'(b[5:0]) + i);
        return {b[14:6], lo};
    endfunction

    // ---------------- operation driver ----------------
    logic got_done, got_to, short_seen, busy_at_done;

    task automatic run_op(input int v, input logic [14:0] b, input logic [5:0] m1,
                          input logic unl, input logic tg, input int prog,
                          input logic stuck, input int nfeed);
        int cyc;
        clear_logs();
        m_prog = prog; m_stuck = stuck;
        got_done = 0; got_to = 0; short_seen = 0; busy_at_done = 0;
        @(negedge clk);
        start = 1'b1; start_addr = b; byte_cnt_m1 = m1; unlock_en = unl; toggle_mode = tg;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nfeed; i++) begin
            in_valid = 1'b1;
            in_data  = bytef(v, i);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        cyc = 0;
        while (cyc < 10000) begin
            if (done) begin
                got_done = 1; short_seen = short_load; busy_at_done = mbusy;
                break;
            end
            if (timeout) begin got_to = 1; break; end
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [14:0] base;
        logic [5:0]  m1;
        logic        unl;
        logic        tog;
        logic [15:0] prog;
        logic        stuck;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{15'h0100, 6'd0,  1'b0, 1'b0, 16'd300, 1'b0},
        '{15'h23C5, 6'd7,  1'b1, 1'b0, 16'd500, 1'b0},
        '{15'h7FBE, 6'd3,  1'b0, 1'b1, 16'd400, 1'b0},
        '{15'h4000, 6'd63, 1'b1, 1'b1, 16'd200, 1'b0},
        '{15'h1040, 6'd2,  1'b0, 1'b0, 16'd0,   1'b1},
        '{15'h0A0A, 6'd1,  1'b1, 1'b1, 16'd0,   1'b1},
        '{15'h5555, 6'd4,  1'b0, 1'b0, 16'd0,   1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R10", "strobes high after reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(!busy && !done && !timeout && !in_ready, "R10", "idle flags after reset",
            {busy, done, timeout, in_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !in_ready, "R11", "no ready without start", {busy, in_ready}, 0);

        // vector walk
        for (int v = 0; v < 7; v++) begin
            vec_t  t;
            int    ew, off, mism, rbad;
            logic [14:0] la;
            t = VECS[v];
            run_op(v, t.base, t.m1, t.unl, t.tog, int'(t.prog), t.stuck, int'(t.m1) + 1);
            off = t.unl ? 3 : 0;
            ew  = int'(t.m1) + 1 + off;
            chk(nw == ew, "R3", $sformatf("vec%0d write count", v), nw, ew);
            if (t.unl) begin
                chk(wlog_a[0] == 15'h5555 && wlog_d[0] == 8'hAA &&
                    wlog_a[1] == 15'h2AAA && wlog_d[1] == 8'h55 &&
                    wlog_a[2] == 15'h5555 && wlog_d[2] == 8'hA0,
                    "R2", $sformatf("vec%0d unlock prefix", v), int'(wlog_d[0]), 'hAA);
            end else begin
                chk(nw == 0 || wlog_a[0] == t.base, "R2", $sformatf("vec%0d no prefix", v), int'(wlog_a[0]), int'(t.base));
            end
            mism = 0;
            for (int i = 0; i <= int'(t.m1); i++) begin
                if (i + off < 128 && (wlog_a[i+off] != paddr(t.base, i) || wlog_d[i+off] != bytef(v, i))) mism++;
            end
            chk(mism == 0, "R3", $sformatf("vec%0d address/data order", v), mism, 0);
            chk(width_bad == 0 && gap_bad == 0, "R4", $sformatf("vec%0d strobe widths/gaps", v), width_bad + gap_bad, 0);
            la = paddr(t.base, int'(t.m1));
            rbad = 0;
            for (int i = 0; i < nr && i < 1024; i++) if (rlog_a[i] != la) rbad++;
            chk(nr > 0 && rbad == 0, "R5", $sformatf("vec%0d poll address", v), rbad, 0);
            if (t.stuck) begin
                chk(got_to && !got_done, "R9", $sformatf("vec%0d timeout when stuck", v), got_to, 1);
            end else if (t.tog) begin
                chk(got_done && !busy_at_done, "R7", $sformatf("vec%0d toggle completion", v), got_done, 1);
            end else begin
                chk(got_done && !busy_at_done, "R6", $sformatf("vec%0d data-bit completion", v), got_done, 1);
            end
            chk(!short_seen, "R8", $sformatf("vec%0d no short flag", v), short_seen, 0);
            chk(!busy && !done && !timeout, "R10", $sformatf("vec%0d single-cycle end", v), {busy, done, timeout}, 0);
        end

        // R8 load deadline: 2 of 4 bytes supplied
        run_op(9, 15'h3210, 6'd3, 1'b0, 1'b0, 100, 1'b0, 2);
        chk(nw == 2, "R8", "writes after stall", nw, 2);
        chk(got_done && short_seen, "R8", "done with short_load", short_seen, 1);
        chk(nr > 0 && rlog_a[0] == paddr(15'h3210, 1), "R8", "poll of last byte written",
            int'(rlog_a[0]), int'(paddr(15'h3210, 1)));

        // R1 start ignored while busy
        begin
            int nw0, nr0;
            clear_logs();
            m_prog = 200; m_stuck = 1'b0;
            @(negedge clk);
            start = 1'b1; start_addr = 15'h0ABC; byte_cnt_m1 = 6'd0; unlock_en = 1'b0; toggle_mode = 1'b0;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R1", "busy after start", busy, 1);
            in_valid = 1'b1; in_data = 8'h3C;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (20) @(negedge clk);
            start = 1'b1; start_addr = 15'h0777; unlock_en = 1'b1;
            @(negedge clk);
            start = 1'b0;
            got_done = 0;
            for (int c = 0; c < 5000 && !got_done; c++) begin
                if (done) got_done = 1;
                @(negedge clk);
            end
            chk(got_done, "R1", "first operation completes", got_done, 1);
            nw0 = nw; nr0 = nr;
            repeat (30) @(negedge clk);
            chk(nw0 == 1 && wlog_a[0] == 15'h0ABC && wlog_d[0] == 8'h3C, "R1", "second start ignored",
                nw0, 1);
            chk(nw == nw0 && nr == nr0 && !busy, "R1", "no bus activity after done", nw + nr, nw0 + nr0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule